// File: doc/BRIEF.md
# Mode-Programmable Timer/Counter Decade Chain

This block is the counting core of a long-life hour meter and event totalizer. One chain of cascaded BCD decades is shared by every function: three hidden prescaler decades come first and feed a display counter of five full decades plus a leading half digit that can only show a 1. A four-bit mode code chooses which source is fed into the chain and at which decade. The source is either a timebase divided down from the oscillator enable or a rising edge on the start/stop input. Moving that entry point sets the timer resolution or the counter prescale factor without any extra counters.

The block runs entirely on the fast system clock. A single-cycle enable, `tickEn`, marks each oscillator period. The block builds a 1 s pulse from `TICKS_PER_SEC` enables, then a 6 s pulse (0.1 min) and a 36 s pulse (0.01 h) by two divide-by-six stages. Two views of the start/stop input come in from outside: a raw level and a level that a separate filter has already qualified. Beyond the counting modes there is a test mode that steps all five display decades at once, two hold modes, and a mode that clears the whole chain to its power-up state.

Top module: `hour_event_chain`

## Requirements
- R1: While `rstN` is low, and on the first cycles after it rises in a hold mode, the display reads 000000: `digitsBcd` is all zero and `halfDigit` is 0.
- R2: Mode 15 clears the display, all three prescaler decades and the timebase dividers on the next clock edge. This happens whether or not `tickEn` is high. After a clear, a count stored in a prescaler before the clear no longer advances the display.
- R3: While `ssFilt` is high, modes 3, 2, 1 and 0 advance the display once every 6, 36, 360 and 3600 seconds. One second is `TICKS_PER_SEC` enabled cycles. After a clear, the first advance falls on the enabled cycle that completes the first full period.
- R4: In modes 0 to 3 the display does not change while `ssFilt` is low.
- R5: Modes 4/5, 6/7, 8/9 and 10/11 advance the display once per 1, 10, 100 and 1000 events.
- R6: The even mode of each counter pair counts rising edges of `ssFilt` only. The odd mode counts rising edges of `ssRaw` only.
- R7: An event is a low-to-high change between two successive enabled cycles. A level held high counts once. While `tickEn` is low, no input is sampled and the display holds.
- R8: In mode 12, each rising edge of `ssRaw` adds one to each of the five display decades independently: 9 wraps to 0 with no carry, and `halfDigit` is unchanged.
- R9: Modes 13 and 14 hold the display unchanged whatever the inputs do.
- R10: Every display digit stays in 0..9 and carries into the next decade. A carry out of the fifth decade sets `halfDigit`, so 099999 becomes 100000. The count after 199999 is 000000. `digitsBcd[3:0]` is the least significant digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle enable per oscillator period |
| mode | input | 4 | Mode code 0..15 |
| ssRaw | input | 1 | Unfiltered start/stop level |
| ssFilt | input | 1 | Qualified start/stop level (timing active / debounced events) |
| digitsBcd | output | 20 | Five BCD display digits, digit 0 in bits 3:0 |
| halfDigit | output | 1 | Leading half digit (1 when lit) |

## Verification
The properties assume that `mode`, `ssRaw` and `ssFilt` change only between clock edges and stay stable for a whole cycle. They also assume that an event is the rising edge of the sampled level, so a one-cycle pulse aligned with an enabled cycle counts exactly once. The stimulus drives every input on the falling clock edge and makes every event pulse high for one full cycle and low for one full cycle. It only changes mode with the chain in a known state, usually just after a mode 15 cycle. The timebase divisor is shortened to four enables per second, so the 1 h mode finishes within the run.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int PRE_DEC   = 3;
  localparam int DISP_DEC  = 5;
  localparam int CHAIN_DEC = PRE_DEC + DISP_DEC;

  typedef logic [3:0] bcd_t;

  typedef struct packed {
    logic [CHAIN_DEC-1:0] inject;   // one-cycle increment into chain position
    logic                 stepAll;  // test step of every display decade
    logic                 clearAll; // synchronous clear of the chain
  } chainCtl_t;
endpackage

// File: rtl/hec_decade.sv
module hec_decade
  import hec_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic inc,
  output bcd_t val
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      val <= '0;
    else if (clr)   val <= '0;
    else if (inc)   val <= (val == 4'd9) ? 4'd0 : val + 4'd1;
  end
endmodule

// File: rtl/hec_ctrl.sv
module hec_ctrl
  import hec_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic [3:0] mode,
  input  logic      ssRaw,
  input  logic      ssFilt,
  output chainCtl_t ctl
);
  localparam int TW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_SEC - 1);

  logic [TW-1:0] tickCnt;
  logic [2:0]    sixA, sixB;
  logic          rawQ, filtQ;
  logic          clearNow, secPulse, sixPulse, p36Pulse, rawRise, filtRise;

  assign clearNow = (mode == 4'd15);
  assign secPulse = tickEn && !clearNow && (tickCnt == TICK_LAST);
  assign sixPulse = secPulse && (sixA == 3'd5);
  assign p36Pulse = sixPulse && (sixB == 3'd5);
  assign rawRise  = tickEn && ssRaw  && !rawQ;
  assign filtRise = tickEn && ssFilt && !filtQ;

  // timebase dividers: 1 s, 6 s, 36 s
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      sixA    <= '0;
      sixB    <= '0;
    end else if (clearNow) begin
      tickCnt <= '0;
      sixA    <= '0;
      sixB    <= '0;
    end else if (tickEn) begin
      tickCnt <= secPulse ? '0 : tickCnt + 1'b1;
      if (secPulse) sixA <= (sixA == 3'd5) ? 3'd0 : sixA + 3'd1;
      if (sixPulse) sixB <= (sixB == 3'd5) ? 3'd0 : sixB + 3'd1;
    end
  end

  // start/stop level history, sampled on enabled cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= 1'b0;
      filtQ <= 1'b0;
    end else if (tickEn) begin
      rawQ  <= ssRaw;
      filtQ <= ssFilt;
    end
  end

  // mode decode: choose source and entry point in the chain
  always_comb begin
    ctl = '0;
    case (mode)
      4'd0:  ctl.inject[0+1] = ssFilt && p36Pulse;
      4'd1:  ctl.inject[2]   = ssFilt && p36Pulse;
      4'd2:  ctl.inject[3]   = ssFilt && p36Pulse;
      4'd3:  ctl.inject[3]   = ssFilt && sixPulse;
      4'd4:  ctl.inject[3]   = filtRise;
      4'd5:  ctl.inject[3]   = rawRise;
      4'd6:  ctl.inject[2]   = filtRise;
      4'd7:  ctl.inject[2]   = rawRise;
      4'd8:  ctl.inject[1]   = filtRise;
      4'd9:  ctl.inject[1]   = rawRise;
      4'd10: ctl.inject[0]   = filtRise;
      4'd11: ctl.inject[0]   = rawRise;
      4'd12: ctl.stepAll     = rawRise;
      4'd15: ctl.clearAll    = 1'b1;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/hec_datapath.sv
module hec_datapath
  import hec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  chainCtl_t             ctl,
  output logic [DISP_DEC*4-1:0] digitsBcd,
  output logic                  halfDigit
);
  bcd_t                 vals [CHAIN_DEC];
  logic [CHAIN_DEC-1:0] incr;
  logic [CHAIN_DEC-1:0] carry;

  always_comb begin
    for (int i = 0; i < CHAIN_DEC; i++) begin
      if (i == 0)
        incr[i] = ctl.inject[i];
      else if (i < PRE_DEC)
        incr[i] = ctl.inject[i] | carry[i-1];
      else
        incr[i] = ctl.inject[i] | (carry[i-1] & ~ctl.stepAll) | ctl.stepAll;
      carry[i] = incr[i] && (vals[i] == 4'd9);
    end
  end

  for (genvar g = 0; g < CHAIN_DEC; g++) begin : g_dec
    hec_decade u_dec (
      .clk (clk),
      .rstN(rstN),
      .clr (ctl.clearAll),
      .inc (incr[g]),
      .val (vals[g])
    );
    if (g >= PRE_DEC) begin : g_disp
      assign digitsBcd[4*(g-PRE_DEC) +: 4] = vals[g];
    end
  end

  // half digit acts as a carry flag; a second carry wraps it back to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     halfDigit <= 1'b0;
    else if (ctl.clearAll)                         halfDigit <= 1'b0;
    else if (carry[CHAIN_DEC-1] && !ctl.stepAll)   halfDigit <= ~halfDigit;
  end
endmodule

// File: rtl/hour_event_chain.sv
module hour_event_chain
  import hec_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [3:0]  mode,
  input  logic        ssRaw,
  input  logic        ssFilt,
  output logic [19:0] digitsBcd,
  output logic        halfDigit
);
  chainCtl_t ctl;

  hec_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .tickEn(tickEn),
    .mode  (mode),
    .ssRaw (ssRaw),
    .ssFilt(ssFilt),
    .ctl   (ctl)
  );

  hec_datapath u_data (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .digitsBcd(digitsBcd),
    .halfDigit(halfDigit)
  );
endmodule

// File: rtl/hec_chk.sv
module hec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tickEn,
  input logic [3:0]  mode,
  input logic        ssRaw,
  input logic        ssFilt,
  input logic [19:0] digitsBcd,
  input logic        halfDigit
);
  logic rawSeen;
  logic digitsOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rawSeen <= 1'b0;
    else if (tickEn) rawSeen <= ssRaw;
  end

  always_comb begin
    digitsOk = 1'b1;
    for (int d = 0; d < 5; d++)
      if (digitsBcd[4*d +: 4] > 4'd9) digitsOk = 1'b0;
  end

  assert_digit_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    digitsOk);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd15) |=> (digitsBcd == 20'd0) && !halfDigit);

  assert_hold_modes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd13 || mode == 4'd14) |=> $stable(digitsBcd) && $stable(halfDigit));

  assert_timer_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode < 4'd4 && !ssFilt) |=> $stable(digitsBcd) && $stable(halfDigit));

  assert_no_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && mode != 4'd15) |=> $stable(digitsBcd) && $stable(halfDigit));

  assert_step_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 4'd12 && tickEn && ssRaw && !rawSeen) |=>
      (digitsBcd[3:0] == (($past(digitsBcd[3:0]) == 4'd9) ? 4'd0 : $past(digitsBcd[3:0]) + 4'd1))
      && $stable(halfDigit));
endmodule

bind hour_event_chain hec_chk i_chk (.*);

// File: tb/test_hour_event_chain.sv
module test_hour_event_chain;
  localparam int TPS = 4;

  typedef struct packed {
    logic [3:0]  mode;
    logic        useRaw;
    logic [15:0] n;
    logic [19:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  1'b0, 16'd7,    20'd7},
    '{4'd5,  1'b1, 16'd13,   20'd13},
    '{4'd6,  1'b0, 16'd25,   20'd2},
    '{4'd7,  1'b1, 16'd39,   20'd3},
    '{4'd8,  1'b0, 16'd250,  20'd2},
    '{4'd9,  1'b1, 16'd199,  20'd1},
    '{4'd10, 1'b0, 16'd2000, 20'd2},
    '{4'd11, 1'b1, 16'd999,  20'd0},
    '{4'd4,  1'b1, 16'd5,    20'd0},
    '{4'd5,  1'b0, 16'd5,    20'd0}
  };

  logic        clk = 1'b0;
  logic        rstN, tickEn, ssRaw, ssFilt;
  logic [3:0]  mode;
  logic [19:0] digitsBcd;
  logic        halfDigit;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  hour_event_chain #(.TICKS_PER_SEC(TPS)) i_hour_event_chain (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .mode(mode),
    .ssRaw(ssRaw), .ssFilt(ssFilt),
    .digitsBcd(digitsBcd), .halfDigit(halfDigit)
  );

  function automatic int dispVal();
    int v = 0;
    for (int d = 4; d >= 0; d--) v = v * 10 + int'(digitsBcd[4*d +: 4]);
    return v + (halfDigit ? 100000 : 0);
  endfunction

  task automatic check(input string tag, input int exp);
    int act = dispVal();
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic startMode(input logic [3:0] m, input logic filtLvl);
    @(negedge clk); mode = 4'd15; ssRaw = 1'b0; ssFilt = 1'b0;
    @(negedge clk); mode = m;     ssFilt = filtLvl;
  endtask

  task automatic pulse(input logic useRaw, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (useRaw) ssRaw = 1'b1; else ssFilt = 1'b1;
      @(negedge clk); if (useRaw) ssRaw = 1'b0; else ssFilt = 1'b0;
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b1; mode = 4'd13; ssRaw = 1'b0; ssFilt = 1'b0;
    waitCyc(3);
    check("R1", 0);
    rstN = 1'b1;
    waitCyc(2);
    check("R1", 0);

    // counter vectors: R5 prescale factors, R6 input selection
    for (int i = 0; i < NV; i++) begin
      startMode(VECS[i].mode, 1'b0);
      pulse(VECS[i].useRaw, int'(VECS[i].n));
      waitCyc(1);
      check((VECS[i].useRaw != VECS[i].mode[0]) ? "R6" : "R5", int'(VECS[i].exp));
    end

    // R2: clear also empties the prescalers
    startMode(4'd9, 1'b0);
    pulse(1'b1, 50);
    waitCyc(1);
    check("R2", 0);
    startMode(4'd9, 1'b0);
    check("R2", 0);
    pulse(1'b1, 60);
    waitCyc(1);
    check("R2", 0);
    pulse(1'b1, 40);
    waitCyc(1);
    check("R5", 1);

    // R7: held level counts once; nothing happens without enable
    startMode(4'd5, 1'b0);
    @(negedge clk); ssRaw = 1'b1;
    waitCyc(10);
    ssRaw = 1'b0;
    waitCyc(1);
    check("R7", 1);
    tickEn = 1'b0;
    pulse(1'b1, 4);
    waitCyc(1);
    check("R7", 1);
    tickEn = 1'b1;
    pulse(1'b1, 1);
    waitCyc(1);
    check("R7", 2);

    // R8 step mode and R10 carries / wrap
    startMode(4'd12, 1'b0);
    pulse(1'b1, 3);
    waitCyc(1);
    check("R8", 33333);
    pulse(1'b1, 7);
    waitCyc(1);
    check("R8", 0);
    pulse(1'b1, 9);
    waitCyc(1);
    check("R8", 99999);
    @(negedge clk); mode = 4'd5;
    pulse(1'b1, 1);
    waitCyc(1);
    check("R10", 100000);
    @(negedge clk); mode = 4'd12;
    pulse(1'b1, 9);
    waitCyc(1);
    check("R8", 199999);
    @(negedge clk); mode = 4'd5;
    pulse(1'b1, 1);
    waitCyc(1);
    check("R10", 0);

    // R9 hold modes
    startMode(4'd5, 1'b0);
    pulse(1'b1, 4);
    @(negedge clk); mode = 4'd13;
    pulse(1'b1, 3);
    pulse(1'b0, 3);
    waitCyc(1);
    check("R9", 4);
    @(negedge clk); mode = 4'd14;
    pulse(1'b1, 3);
    pulse(1'b0, 3);
    waitCyc(1);
    check("R9", 4);

    // R3 timer rates, R4 inactive timing
    startMode(4'd3, 1'b1);
    waitCyc(6 * TPS * 3 + 2);
    check("R3", 3);
    ssFilt = 1'b0;
    waitCyc(6 * TPS * 2);
    check("R4", 3);
    ssFilt = 1'b1;
    waitCyc(6 * TPS);
    check("R3", 4);

    startMode(4'd2, 1'b1);
    waitCyc(36 * TPS * 2 + 2);
    check("R3", 2);

    startMode(4'd1, 1'b1);
    waitCyc(360 * TPS - 2);
    check("R3", 0);
    waitCyc(4);
    check("R3", 1);

    startMode(4'd0, 1'b1);
    waitCyc(3600 * TPS - 2);
    check("R3", 0);
    waitCyc(4);
    check("R3", 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule